// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Unit

This block holds the two threshold offsets that drive a FIFO's almost-empty and almost-full indications, and it produces both flags from the FIFO's current fill level. The FIFO storage and its pointers are outside the block. The FIFO supplies its fill level (a word count from 0 to DEPTH), and the block returns two combinational flags.

The offsets can come from three places, and the choice is made once, on the first clock after the full reset is released:
- **Preset.** One of three fixed values is loaded into both offsets, picked by a two-bit select input.
- **Parallel load.** The offsets are loaded by the first two writes on the parallel data bus.
- **Serial load.** The offsets are shifted in one bit per clock. In this mode the two select pins are reused as the serial data bit and the serial enable.

A partial reset input stands for the FIFO being flushed. It leaves the programmed offsets alone and suppresses loading while it is high. Only a full reset restarts configuration.

Top module: `almost_flag_unit`

## Requirements
- R1: While rst_ni is low both offsets are 0, so almost_empty_o is high only at fill level 0 and almost_full_o is high only at fill level DEPTH. On the first rising clock edge with rst_ni high, the block samples ser_mode_i and cfg_sel_i once to choose its configuration source.
- R2: If ser_mode_i is 0 at that sampling edge and cfg_sel_i is 2'b01, 2'b10 or 2'b11, then both offsets are loaded with 8, 16 or 64 respectively. No further programming is accepted after that.
- R3: If ser_mode_i is 1 at that sampling edge, serial loading starts. On each clock edge where cfg_sel_i[1] (the serial enable) is high, the bit on cfg_sel_i[0] is shifted in. The first 10 bits form the almost-empty offset and the next 10 bits form the almost-full offset, each sent MSB first. After the 20th bit, further enabled bits are ignored.
- R4: During serial loading, a clock edge with cfg_sel_i[1] low changes neither offset, even when wr_en_i is high.
- R5: If ser_mode_i is 0 and cfg_sel_i is 2'b00 at that sampling edge, parallel loading starts. The first accepted write (wr_en_i high) loads the almost-empty offset from wr_data_i, and the second loads the almost-full offset. Clock edges without a write do not advance the sequence, and later writes are ignored.
- R6: almost_empty_o is high exactly when fill_lvl_i is less than or equal to the almost-empty offset.
- R7: almost_full_o is high exactly when DEPTH minus fill_lvl_i is less than or equal to the almost-full offset.
- R8: While part_rst_i is high, serial shifts and parallel writes are ignored, the loading sequence does not advance, and both offsets keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous full reset |
| part_rst_i | input | 1 | Partial reset; retains the offsets and blocks loading |
| ser_mode_i | input | 1 | Sampled after reset: 1 selects serial loading |
| cfg_sel_i | input | 2 | Preset select after reset; in serial mode [0] is data and [1] is enable |
| wr_en_i | input | 1 | Parallel offset write strobe |
| wr_data_i | input | OFS_W (10) | Low bits of the parallel data bus |
| fill_lvl_i | input | LVL_W (11) | FIFO fill level, from 0 to DEPTH |
| almost_empty_o | output | 1 | Fill level is at or below the almost-empty offset |
| almost_full_o | output | 1 | Free space is at or below the almost-full offset |

## Verification
The assertions assume that fill_lvl_i never exceeds DEPTH and that the inputs are stable around the sampling edge. The monotonic flag properties also assume that an offset change is visible as a change in the offset registers. The bench keeps fill levels drawn from $urandom inside 0..DEPTH, and it changes every input only on the falling clock edge. It releases reset on a falling edge, so the configuration sample is taken on a clean rising edge. The random offset values and serial bit patterns come from a fixed seed. Directed cases cover idle gaps, stray writes, partial-reset pulses and surplus bits in the middle of and after each load.

// File: rtl/aflag_pkg.sv
package aflag_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_SER,
    ST_PAR_AE,
    ST_PAR_AF,
    ST_DONE
  } cfg_state_e;

  // preset offset for a nonzero select code
  function automatic logic [15:0] preset_ofs(input logic [1:0] sel);
    case (sel)
      2'b01:   return 16'd8;
      2'b10:   return 16'd16;
      2'b11:   return 16'd64;
      default: return 16'd0;
    endcase
  endfunction
endpackage

// File: rtl/aflag_cfg_fsm.sv
module aflag_cfg_fsm
  import aflag_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       part_rst_i,
  input  logic       ser_mode_i,
  input  logic [1:0] cfg_sel_i,
  input  logic       wr_en_i,
  output cfg_state_e state_o,
  output logic       preset_ld_o,
  output logic       shift_o,
  output logic       ld_ae_o,
  output logic       ld_af_o
);
  localparam int NBITS = 2 * OFS_W;
  localparam int CNT_W = $clog2(NBITS + 1);

  cfg_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    preset_ld_o = (state_q == ST_INIT) && !ser_mode_i && (cfg_sel_i != 2'b00);
    shift_o     = (state_q == ST_SER) && cfg_sel_i[1] && !part_rst_i;
    ld_ae_o     = (state_q == ST_PAR_AE) && wr_en_i && !part_rst_i;
    ld_af_o     = (state_q == ST_PAR_AF) && wr_en_i && !part_rst_i;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_INIT: begin
        if (ser_mode_i)               state_d = ST_SER;
        else if (cfg_sel_i == 2'b00)  state_d = ST_PAR_AE;
        else                          state_d = ST_DONE;
      end
      ST_SER: begin
        if (shift_o) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(NBITS - 1)) state_d = ST_DONE;
        end
      end
      ST_PAR_AE: if (ld_ae_o) state_d = ST_PAR_AF;
      ST_PAR_AF: if (ld_af_o) state_d = ST_DONE;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_INIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/aflag_ofs_regs.sv
module aflag_ofs_regs #(
  parameter int OFS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preset_ld_i,
  input  logic [OFS_W-1:0] preset_i,
  input  logic             shift_i,
  input  logic             sdat_i,
  input  logic             ld_ae_i,
  input  logic             ld_af_i,
  input  logic [OFS_W-1:0] wdata_i,
  output logic [OFS_W-1:0] ae_ofs_o,
  output logic [OFS_W-1:0] af_ofs_o
);
  logic [OFS_W-1:0] ae_q, af_q;

  // serial chain: ae (MSB end) <- af <- sdat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q <= '0;
      af_q <= '0;
    end else if (preset_ld_i) begin
      ae_q <= preset_i;
      af_q <= preset_i;
    end else if (shift_i) begin
      ae_q <= {ae_q[OFS_W-2:0], af_q[OFS_W-1]};
      af_q <= {af_q[OFS_W-2:0], sdat_i};
    end else if (ld_ae_i) begin
      ae_q <= wdata_i;
    end else if (ld_af_i) begin
      af_q <= wdata_i;
    end
  end

  assign ae_ofs_o = ae_q;
  assign af_ofs_o = af_q;
endmodule

// File: rtl/aflag_cmp.sv
module aflag_cmp #(
  parameter int W = 11
) (
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] thr_i,
  output logic         le_o
);
  assign le_o = (lvl_i <= thr_i);
endmodule

// File: rtl/almost_flag_unit.sv
module almost_flag_unit
  import aflag_pkg::*;
#(
  parameter int  DEPTH = 1024,
  parameter int  OFS_W = 10,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             part_rst_i,
  input  logic             ser_mode_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic             wr_en_i,
  input  logic [OFS_W-1:0] wr_data_i,
  input  logic [LVL_W-1:0] fill_lvl_i,
  output logic             almost_empty_o,
  output logic             almost_full_o
);
  cfg_state_e       cfg_state;
  logic             preset_ld, shift, ld_ae, ld_af;
  logic [OFS_W-1:0] preset_val, ae_ofs, af_ofs;
  logic [LVL_W-1:0] free_lvl;

  assign preset_val = OFS_W'(preset_ofs(cfg_sel_i));
  assign free_lvl   = LVL_W'(DEPTH) - fill_lvl_i;

  aflag_cfg_fsm #(.OFS_W(OFS_W)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .part_rst_i (part_rst_i),
    .ser_mode_i (ser_mode_i),
    .cfg_sel_i  (cfg_sel_i),
    .wr_en_i    (wr_en_i),
    .state_o    (cfg_state),
    .preset_ld_o(preset_ld),
    .shift_o    (shift),
    .ld_ae_o    (ld_ae),
    .ld_af_o    (ld_af)
  );

  aflag_ofs_regs #(.OFS_W(OFS_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .preset_ld_i(preset_ld),
    .preset_i   (preset_val),
    .shift_i    (shift),
    .sdat_i     (cfg_sel_i[0]),
    .ld_ae_i    (ld_ae),
    .ld_af_i    (ld_af),
    .wdata_i    (wr_data_i),
    .ae_ofs_o   (ae_ofs),
    .af_ofs_o   (af_ofs)
  );

  aflag_cmp #(.W(LVL_W)) i_cmp_ae (
    .lvl_i(fill_lvl_i),
    .thr_i(LVL_W'(ae_ofs)),
    .le_o (almost_empty_o)
  );

  aflag_cmp #(.W(LVL_W)) i_cmp_af (
    .lvl_i(free_lvl),
    .thr_i(LVL_W'(af_ofs)),
    .le_o (almost_full_o)
  );
endmodule

// File: rtl/aflag_chk.sv
module aflag_chk
  import aflag_pkg::*;
#(
  parameter int  DEPTH = 1024,
  parameter int  OFS_W = 10,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             part_rst_i,
  input logic             ser_mode_i,
  input logic [1:0]       cfg_sel_i,
  input logic             wr_en_i,
  input logic [LVL_W-1:0] fill_lvl_i,
  input logic             almost_empty_o,
  input logic             almost_full_o,
  input cfg_state_e       cfg_state,
  input logic [OFS_W-1:0] ae_ofs,
  input logic [OFS_W-1:0] af_ofs
);
  AST_PRESET_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_state == ST_INIT && !ser_mode_i && cfg_sel_i != 2'b00) |=>
      (ae_ofs == af_ofs) &&
      (ae_ofs == (($past(cfg_sel_i) == 2'b01) ? OFS_W'(8) :
                  ($past(cfg_sel_i) == 2'b10) ? OFS_W'(16) : OFS_W'(64)))); // R2

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_state == ST_DONE) |=> ($stable(ae_ofs) && $stable(af_ofs))); // R3

  AST_SER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_state == ST_SER && !cfg_sel_i[1]) |=> ($stable(ae_ofs) && $stable(af_ofs))); // R4

  AST_PAR_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_state == ST_PAR_AE && !wr_en_i) |=> (cfg_state == ST_PAR_AE && $stable(ae_ofs))); // R5

  AST_AE_AT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_lvl_i == '0) |-> almost_empty_o); // R6

  AST_AE_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(almost_empty_o) && $stable(ae_ofs) && fill_lvl_i <= $past(fill_lvl_i))
      |-> almost_empty_o); // R6

  AST_AF_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_lvl_i == LVL_W'(DEPTH)) |-> almost_full_o); // R7

  AST_AF_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(almost_full_o) && $stable(af_ofs) && fill_lvl_i >= $past(fill_lvl_i))
      |-> almost_full_o); // R7

  AST_PART_RST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_rst_i && cfg_state != ST_INIT) |=>
      ($stable(ae_ofs) && $stable(af_ofs) && $stable(cfg_state))); // R8
endmodule

bind almost_flag_unit aflag_chk #(.DEPTH(DEPTH), .OFS_W(OFS_W)) i_aflag_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .part_rst_i    (part_rst_i),
  .ser_mode_i    (ser_mode_i),
  .cfg_sel_i     (cfg_sel_i),
  .wr_en_i       (wr_en_i),
  .fill_lvl_i    (fill_lvl_i),
  .almost_empty_o(almost_empty_o),
  .almost_full_o (almost_full_o),
  .cfg_state     (cfg_state),
  .ae_ofs        (ae_ofs),
  .af_ofs        (af_ofs)
);

// File: tb/test_almost_flag_unit.sv
`timescale 1ns/1ps
module test_almost_flag_unit;
  localparam int DEPTH = 1024;
  localparam int OFS_W = 10;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             part_rst_i = 1'b0;
  logic             ser_mode_i = 1'b0;
  logic [1:0]       cfg_sel_i = 2'b00;
  logic             wr_en_i = 1'b0;
  logic [OFS_W-1:0] wr_data_i = '0;
  logic [LVL_W-1:0] fill_lvl_i = '0;
  logic             almost_empty_o, almost_full_o;

  int n_cmp = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  almost_flag_unit #(.DEPTH(DEPTH), .OFS_W(OFS_W)) i_almost_flag_unit (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .part_rst_i    (part_rst_i),
    .ser_mode_i    (ser_mode_i),
    .cfg_sel_i     (cfg_sel_i),
    .wr_en_i       (wr_en_i),
    .wr_data_i     (wr_data_i),
    .fill_lvl_i    (fill_lvl_i),
    .almost_empty_o(almost_empty_o),
    .almost_full_o (almost_full_o)
  );

  function automatic bit exp_ae(int fill, int ofs);
    return fill <= ofs;
  endfunction

  function automatic bit exp_af(int fill, int ofs);
    return (DEPTH - fill) <= ofs;
  endfunction

  task automatic chk(bit act, bit exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // drive a fill level and compare both flags against the model
  task automatic probe(int fill, int ae, int af, string tag);
    @(negedge clk);
    fill_lvl_i = LVL_W'(fill);
    #1;
    chk(almost_empty_o, exp_ae(fill, ae), {tag, " almost_empty"});
    chk(almost_full_o,  exp_af(fill, af), {tag, " almost_full"});
  endtask

  task automatic check_offsets(int ae, int af, string tag);
    probe(ae, ae, af, tag);
    probe(ae + 1, ae, af, tag);
    probe(DEPTH - af, ae, af, tag);
    if (af < DEPTH) probe(DEPTH - af - 1, ae, af, tag);
  endtask

  task automatic full_reset(bit mode, logic [1:0] sel);
    @(negedge clk);
    rst_ni = 1'b0; ser_mode_i = mode; cfg_sel_i = sel;
    wr_en_i = 1'b0; part_rst_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);  // sampling edge has passed
    cfg_sel_i = 2'b00;
    ser_mode_i = 1'b0;
  endtask

  task automatic par_write(logic [OFS_W-1:0] d, bit prst);
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = d; part_rst_i = prst;
    @(negedge clk);
    wr_en_i = 1'b0; part_rst_i = 1'b0;
  endtask

  task automatic ser_bit(bit b, bit prst);
    @(negedge clk);
    cfg_sel_i = {1'b1, b}; part_rst_i = prst;
    @(negedge clk);
    cfg_sel_i = 2'b00; part_rst_i = 1'b0;
  endtask

  task automatic rand_sweep(int ae, int af, int n);
    for (int k = 0; k < n; k++) begin
      int f;
      f = int'($urandom_range(DEPTH, 0));
      probe(f, ae, af, "R6/R7 random");
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    int ae, af;
    logic [OFS_W-1:0] va, vf;
    void'($urandom(32'd1234));

    // R1: reset state, offsets zero
    repeat (2) @(negedge clk);
    probe(0, 0, 0, "R1 reset");
    probe(1, 0, 0, "R1 reset");
    probe(DEPTH, 0, 0, "R1 reset");
    probe(DEPTH - 1, 0, 0, "R1 reset");

    // R2: presets
    full_reset(1'b0, 2'b01);
    check_offsets(8, 8, "R2 preset 8");
    full_reset(1'b0, 2'b10);
    check_offsets(16, 16, "R2 preset 16");
    full_reset(1'b0, 2'b11);
    check_offsets(64, 64, "R2 preset 64");
    par_write(10'd500, 1'b0);   // ignored after preset
    check_offsets(64, 64, "R2 write after preset");

    // R5 / R8: parallel load
    for (int t = 0; t < 3; t++) begin
      va = OFS_W'($urandom);
      vf = OFS_W'($urandom);
      if (t == 0) begin va = '0; vf = '1; end
      full_reset(1'b0, 2'b00);
      repeat (3) @(negedge clk);
      par_write(~va, 1'b1);     // blocked by partial reset
      par_write(va, 1'b0);
      check_offsets(int'(va), 0, "R5 first write");
      par_write(~vf, 1'b1);     // blocked by partial reset
      par_write(vf, 1'b0);
      par_write(~vf, 1'b0);     // surplus write
      check_offsets(int'(va), int'(vf), "R5/R8 parallel");
      rand_sweep(int'(va), int'(vf), 40);
    end

    // R3 / R4 / R8: serial load
    for (int t = 0; t < 3; t++) begin
      va = OFS_W'($urandom);
      vf = OFS_W'($urandom);
      if (t == 0) begin va = 10'd1023; vf = 10'd0; end
      full_reset(1'b1, 2'b00);
      for (int i = OFS_W - 1; i >= 0; i--) begin
        if (i == 4) begin
          par_write(10'h155, 1'b0);   // R4 idle edge with a write
          ser_bit(~va[i], 1'b1);      // R8 blocked shift
        end
        ser_bit(va[i], 1'b0);
      end
      check_offsets(0, int'(va), "R3 half loaded");
      for (int i = OFS_W - 1; i >= 0; i--) ser_bit(vf[i], 1'b0);
      for (int k = 0; k < 3; k++) ser_bit(1'b1, 1'b0);  // surplus bits
      check_offsets(int'(va), int'(vf), "R3/R4 serial");
      rand_sweep(int'(va), int'(vf), 40);
    end

    // R8: partial reset after programming retains offsets
    ae = 300; af = 200;
    full_reset(1'b0, 2'b00);
    par_write(10'(ae), 1'b0);
    par_write(10'(af), 1'b0);
    @(negedge clk);
    part_rst_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 10'd5;
    repeat (4) @(negedge clk);
    part_rst_i = 1'b0; wr_en_i = 1'b0;
    check_offsets(ae, af, "R8 after partial reset");
    rand_sweep(ae, af, 60);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule